// File: doc/BRIEF.md
# Fan PWM Generator Channel

This block produces one pulse-width modulated waveform for a cooling fan. The input clock first passes through a power-of-two divider and then a linear divider of 1 to 256. Each tick from this prescaler advances an 8-bit period counter. The counter runs from zero up to a programmed period value and then wraps to zero. Within each period the pin is driven high from a programmed rising point until a programmed falling point. It can be inverted, driven in open-drain style, or held at a fixed level while the waveform is stopped.

Software writes two words through a single-cycle write strobe: a control word and a duty word. A two-state machine decides whether the waveform runs. In `ST_IDLE` the counters are cleared and the pin shows the static level. The transition `ST_IDLE -> ST_RUN` is taken when the clock enable and pin enable are both set and the duty word is not zero. The transition `ST_RUN -> ST_IDLE` is taken as soon as any of those conditions is lost. While the machine is in `ST_RUN`, a written duty word is normally copied into the active compare registers only when the period wraps. A control bit can make the copy happen on every cycle instead.

Top module: `fan_pwm_channel`

## Requirements
- R1: After reset the control and duty words are zero, `pwm_o` is 0 and `pwm_oe_n` is 1.
- R2: The 4-bit field H in control bits 11:8 divides the clock by 2^H. H=0 gives one tick per cycle and H=15 gives one tick every 32768 cycles.
- R3: The 8-bit field L in control bits 7:0 further divides the H-stage ticks by L+1. One counter step therefore takes 2^H*(L+1) cycles.
- R4: The period counter steps from 0 to the period field P (duty bits 31:24) and then returns to 0. One period is therefore P+1 counter steps.
- R5: With rising point R (duty bits 7:0) and falling point F (duty bits 15:8), the waveform is high for counts c where R<=c<F when R<F. It is high where c>=R or c<F when R>F.
- R6: When R equals F, the waveform stays low for the whole period.
- R7: The waveform runs only while clock enable (control bit 16) and pin enable (control bit 12) are both set. Otherwise the pin takes the static level in control bit 15.
- R8: Control bit 14 inverts the pin value, including the static level.
- R9: With pin enable clear, `pwm_oe_n` is 1. With pin enable and open drain (control bit 13) both set, `pwm_o` is 0 and `pwm_oe_n` carries the pin value. Otherwise `pwm_oe_n` is 0 and `pwm_o` carries the pin value.
- R10: While control bit 17 is clear, a new duty word takes effect only when the counter wraps from P to 0.
- R11: While control bit 17 is set, a new duty word reaches the active compare registers one cycle after it is written.
- R12: A duty word whose period, falling and rising fields are all zero stops the channel and shows the static level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe, one cycle per word |
| cfg_sel | input | 1 | 0 selects the control word, 1 selects the duty word |
| cfg_wdata | input | 32 | Word being written |
| pwm_o | output | 1 | Pin value, registered |
| pwm_oe_n | output | 1 | Active-low output enable, registered |

## Verification
The two functions that can fall in the same cycle are a duty word write and a period wrap. They collide when the write lands on the cycle in which the counter returns to zero and the active copy is taken. The bench provokes this with a three-count period at full clock rate. It writes new duty words at gaps of one to eight cycles, so some writes land exactly on the wrap, some one cycle before it and some one cycle after it. A behavioural reference model is compared with both outputs on every clock. The model decides from the register values held before the edge whether the old or the new duty applies in the following period.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_RUN} fpwm_state_e;

    // control word bit positions
    localparam int CTL_SYNC_DIS = 17;
    localparam int CTL_CLK_EN   = 16;
    localparam int CTL_LEVEL    = 15;
    localparam int CTL_INVERT   = 14;
    localparam int CTL_ODRAIN   = 13;
    localparam int CTL_PIN_EN   = 12;
    localparam int CTL_H_LSB    = 8;
    localparam int CTL_L_LSB    = 0;
    localparam int CTL_W        = CTL_SYNC_DIS + 1;

    // duty word field positions
    localparam int DUTY_PER_LSB  = 24;
    localparam int DUTY_FALL_LSB = 8;
    localparam int DUTY_RISE_LSB = 0;
endpackage

// File: rtl/fpwm_prescale.sv
module fpwm_prescale #(
    parameter int HSEL_W = 4,
    parameter int LDIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HSEL_W-1:0] hsel,
    input  logic [LDIV_W-1:0] ldiv,
    output logic              tick
);
    localparam int HCNT_W = (1 << HSEL_W) - 1;

    logic [HCNT_W-1:0] hcnt_q;
    logic [HCNT_W-1:0] hmask;
    logic [LDIV_W-1:0] lcnt_q;
    logic              h_tick;

    for (genvar gi = 0; gi < HCNT_W; gi++) begin : g_mask
        assign hmask[gi] = (gi < int'(hsel));
    end

    assign h_tick = &(hcnt_q | ~hmask);
    assign tick   = h_tick && (lcnt_q == ldiv);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q <= '0;
            lcnt_q <= '0;
        end else if (!run) begin
            hcnt_q <= '0;
            lcnt_q <= '0;
        end else begin
            hcnt_q <= hcnt_q + HCNT_W'(1);
            if (h_tick)
                lcnt_q <= (lcnt_q == ldiv) ? '0 : lcnt_q + LDIV_W'(1);
        end
    end
endmodule

// File: rtl/fpwm_seq.sv
module fpwm_seq
    import fpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_cfg,
    input  logic             sync_dis,
    input  logic             tick,
    input  logic [CNT_W-1:0] new_per,
    input  logic [CNT_W-1:0] new_rise,
    input  logic [CNT_W-1:0] new_fall,
    output logic             running,
    output logic [CNT_W-1:0] pcnt,
    output logic [CNT_W-1:0] act_rise,
    output logic [CNT_W-1:0] act_fall
);
    fpwm_state_e      state_q, state_d;
    logic [CNT_W-1:0] pcnt_q, per_q, rise_q, fall_q;
    logic             wrap;

    assign wrap = tick && (pcnt_q == per_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en_cfg)  state_d = ST_RUN;
            ST_RUN:  if (!en_cfg) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            per_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (state_q == ST_IDLE || !en_cfg) begin
            pcnt_q <= '0;
            per_q  <= new_per;
            rise_q <= new_rise;
            fall_q <= new_fall;
        end else begin
            if (tick)
                pcnt_q <= wrap ? '0 : pcnt_q + CNT_W'(1);
            if (sync_dis || wrap) begin
                per_q  <= new_per;
                rise_q <= new_rise;
                fall_q <= new_fall;
            end
        end
    end

    always_comb begin
        running  = (state_q == ST_RUN);
        pcnt     = pcnt_q;
        act_rise = rise_q;
        act_fall = fall_q;
    end

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (pcnt_q == '0));
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en_cfg && tick && pcnt_q == per_q) |=> (pcnt_q == '0));
    assert_hold_duty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en_cfg && !sync_dis && !tick)
        |=> ($stable(per_q) && $stable(rise_q) && $stable(fall_q)));
    assert_fast_duty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en_cfg && sync_dis) |=> (rise_q == $past(new_rise)));
endmodule

// File: rtl/fpwm_shape.sv
module fpwm_shape #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [CNT_W-1:0] pcnt,
    input  logic [CNT_W-1:0] rise,
    input  logic [CNT_W-1:0] fall,
    input  logic             level,
    input  logic             invert,
    input  logic             pin_en,
    input  logic             odrain,
    output logic             pwm_o,
    output logic             oe_n
);
    logic wave, pin;

    always_comb begin
        if (rise < fall)      wave = (pcnt >= rise) && (pcnt < fall);
        else if (rise > fall) wave = (pcnt >= rise) || (pcnt < fall);
        else                  wave = 1'b0;
        pin = (running ? wave : level) ^ invert;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_o <= 1'b0;
            oe_n  <= 1'b1;
        end else if (!pin_en) begin
            pwm_o <= pin;
            oe_n  <= 1'b1;
        end else if (odrain) begin
            pwm_o <= 1'b0;
            oe_n  <= pin;
        end else begin
            pwm_o <= pin;
            oe_n  <= 1'b0;
        end
    end

    assert_od_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en && odrain) |=> (pwm_o == 1'b0));
    assert_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |=> oe_n);
endmodule

// File: rtl/fan_pwm_channel.sv
module fan_pwm_channel
    import fpwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int HSEL_W = 4,
    parameter int LDIV_W = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              pwm_o,
    output logic              pwm_oe_n
);
    logic [CTL_W-1:0] ctrl_q;
    logic [CNT_W-1:0] per_q, rise_q, fall_q;
    logic             en_cfg, tick, running;
    logic [CNT_W-1:0] pcnt, act_rise, act_fall;
    logic             unused_wdata;

    assign unused_wdata = ^{cfg_wdata[WORD_W-1:CTL_W],
                            cfg_wdata[DUTY_PER_LSB-1:DUTY_FALL_LSB+CNT_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            per_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) begin
                per_q  <= cfg_wdata[DUTY_PER_LSB  +: CNT_W];
                fall_q <= cfg_wdata[DUTY_FALL_LSB +: CNT_W];
                rise_q <= cfg_wdata[DUTY_RISE_LSB +: CNT_W];
            end else begin
                ctrl_q <= cfg_wdata[CTL_W-1:0];
            end
        end
    end

    assign en_cfg = ctrl_q[CTL_CLK_EN] && ctrl_q[CTL_PIN_EN] && (|{per_q, rise_q, fall_q});

    fpwm_prescale #(.HSEL_W(HSEL_W), .LDIV_W(LDIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .hsel  (ctrl_q[CTL_H_LSB +: HSEL_W]),
        .ldiv  (ctrl_q[CTL_L_LSB +: LDIV_W]),
        .tick  (tick)
    );

    fpwm_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_cfg   (en_cfg),
        .sync_dis (ctrl_q[CTL_SYNC_DIS]),
        .tick     (tick),
        .new_per  (per_q),
        .new_rise (rise_q),
        .new_fall (fall_q),
        .running  (running),
        .pcnt     (pcnt),
        .act_rise (act_rise),
        .act_fall (act_fall)
    );

    fpwm_shape #(.CNT_W(CNT_W)) u_shape (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .pcnt    (pcnt),
        .rise    (act_rise),
        .fall    (act_fall),
        .level   (ctrl_q[CTL_LEVEL]),
        .invert  (ctrl_q[CTL_INVERT]),
        .pin_en  (ctrl_q[CTL_PIN_EN]),
        .odrain  (ctrl_q[CTL_ODRAIN]),
        .pwm_o   (pwm_o),
        .oe_n    (pwm_oe_n)
    );

    assert_off_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && ctrl_q[CTL_PIN_EN] && !ctrl_q[CTL_ODRAIN])
        |=> (pwm_o == $past(ctrl_q[CTL_LEVEL] ^ ctrl_q[CTL_INVERT])));
endmodule

// File: tb/test_fan_pwm_channel.sv
module test_fan_pwm_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    wire         pwm_o, pwm_oe_n;

    always #10 clk = ~clk;

    fan_pwm_channel i_fan_pwm_channel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .pwm_o(pwm_o), .pwm_oe_n(pwm_oe_n)
    );

    localparam logic [31:0] SD = 32'h1 << 17, CE = 32'h1 << 16, LV = 32'h1 << 15;
    localparam logic [31:0] IV = 32'h1 << 14, OD = 32'h1 << 13, PE = 32'h1 << 12;

    int    total = 0, bad = 0;
    bit    chk_on = 0, done = 0;
    string cur_req = "R1";

    // behavioural reference model
    logic [31:0] m_ctrl, m_duty, m_act;
    bit m_run, m_o, m_oen;
    int m_h, m_l, m_p;

    function automatic bit wave_f(int p, logic [31:0] a);
        int r = a[7:0], f = a[15:8];
        if (r < f) return (p >= r) && (p < f);
        if (r > f) return (p >= r) || (p < f);
        return 0;
    endfunction

    function automatic logic [31:0] duty(int per, int fall, int rise);
        return {per[7:0], 8'h00, fall[7:0], rise[7:0]};
    endfunction

    always @(posedge clk) begin : mdl
        bit pin, en, th, t, bnd;
        int hs, ld, mask;
        if (!rst_n) begin
            m_ctrl = 0; m_duty = 0; m_act = 0; m_run = 0;
            m_h = 0; m_l = 0; m_p = 0; m_o = 0; m_oen = 1;
        end else begin
            pin = (m_run ? wave_f(m_p, m_act) : m_ctrl[15]) ^ m_ctrl[14];
            if (!m_ctrl[12])     begin m_o = pin; m_oen = 1;   end
            else if (m_ctrl[13]) begin m_o = 0;   m_oen = pin; end
            else                 begin m_o = pin; m_oen = 0;   end
            en = m_ctrl[16] && m_ctrl[12] && ({m_duty[31:24], m_duty[15:0]} != 0);
            if (!m_run) begin
                if (en) begin m_run = 1; m_act = m_duty; end
                m_h = 0; m_l = 0; m_p = 0;
            end else if (!en) begin
                m_run = 0; m_h = 0; m_l = 0; m_p = 0;
            end else begin
                hs = m_ctrl[11:8]; ld = m_ctrl[7:0];
                mask = (1 << hs) - 1;
                th = ((m_h & mask) == mask);
                t = th && (m_l == ld);
                bnd = t && (m_p == m_act[31:24]);
                m_h = (m_h + 1) & 32'h7fff;
                if (th) m_l = (m_l == ld) ? 0 : ((m_l + 1) & 255);
                if (t) m_p = bnd ? 0 : ((m_p + 1) & 255);
                if (m_ctrl[17] || bnd) m_act = m_duty;
            end
            if (cfg_we) begin
                if (cfg_sel) m_duty = cfg_wdata;
                else         m_ctrl = cfg_wdata;
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (chk_on && !done) begin
            total++;
            if ({pwm_o, pwm_oe_n} !== {m_o, m_oen}) begin
                bad++;
                $display("FAIL %s: o/oe_n=%b%b expected %b%b at %0t",
                         cur_req, pwm_o, pwm_oe_n, m_o, m_oen, $time);
            end
        end
    end

    task automatic expect_o(string r, bit eo, bit eoen);
        total++;
        if ({pwm_o, pwm_oe_n} !== {eo, eoen}) begin
            bad++;
            $display("FAIL %s: o/oe_n=%b%b expected %b%b", r, pwm_o, pwm_oe_n, eo, eoen);
        end
    endtask

    task automatic wr(bit sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk_on = 1;
        expect_o("R1", 0, 1);
        // R7: clock enable clear shows static level
        cur_req = "R7";
        wr(0, PE | LV); idle(3);
        expect_o("R7", 1, 0);
        // R4 / R5: plain window
        cur_req = "R5";
        wr(1, duty(4, 3, 1)); wr(0, CE | PE); idle(40);
        // R10: wrapped window applied at boundary
        cur_req = "R10";
        wr(1, duty(4, 1, 3)); idle(40);
        cur_req = "R6";
        wr(1, duty(5, 2, 2)); idle(30);
        cur_req = "R2";
        wr(1, duty(3, 2, 0)); wr(0, CE | PE | (32'd2 << 8)); idle(60);
        cur_req = "R3";
        wr(0, CE | PE | (32'd1 << 8) | 32'd2); idle(120);
        cur_req = "R4";
        wr(0, CE | PE); wr(1, duty(6, 4, 0)); idle(40);
        cur_req = "R8";
        wr(0, CE | PE | IV); idle(30);
        cur_req = "R9";
        wr(0, CE | PE | OD); idle(30);
        wr(0, CE | OD); idle(5);
        expect_o("R9", 0, 1);
        cur_req = "R11";
        wr(0, CE | PE | SD); wr(1, duty(9, 5, 1)); idle(3);
        wr(1, duty(9, 8, 2)); idle(25);
        cur_req = "R12";
        wr(1, 32'h0); idle(3);
        expect_o("R12", 0, 0);
        wr(0, CE | PE | LV); idle(3);
        expect_o("R12", 1, 0);
        // R10: writes colliding with period wraps
        cur_req = "R10";
        wr(0, CE | PE); wr(1, duty(2, 1, 0));
        for (int k = 1; k <= 8; k++) begin
            idle(k);
            wr(1, duty(2 + k % 3, k % 3 + 1, 0));
        end
        idle(20);
        chk_on = 0;
        finish_run();
    end
endmodule